// File: doc/BRIEF.md
# Transceiver Lane PCS Mode-Switch Sequencer

This block moves one serial transceiver lane between an 8b/10b coding path and a 64b/66b-style coding path while the lane is running. A requester presents a line-rate code and a flag giving the fabric data width. The block sorts the rate code into one of the two coding families. It then works through the lane's dynamic configuration registers over an APB master port, updating five register groups in a fixed order:

- interface-mode select
- clock source selects
- clock enables
- serializer/deserializer bus widths
- symbol-slip control

Each update is a read-modify-write, so bits outside the target fields keep their values. When the final write completes, the block raises `done` for one cycle and updates `curMode`. An error response on the bus aborts the sequence. A rate code outside the supported set is refused at once with no bus traffic. In both cases `err` pulses and `curMode` keeps its old value.

Register group k sits at byte address `BASE_ADDR + 4*k`, with k from 0 to 4 in the write order given below. A new request arriving while a sequence runs is stalled: `reqAck` stays low until the block is idle again.

Top module: `lane_mode_seq`

## Requirements
- R1: Rate code 4'h2 to 4'h7 selects the 8b/10b path (`curMode`=0 after `done`). Codes 4'h8, 4'h9 and 4'hA (the "7a" rate) select the 64b/66b path (`curMode`=1).
- R2: Register 0 (offset 0x0) receives the one-hot interface mode in bits [3:0]: 4'b0100 for 8b/10b, 4'b0010 for 64b/66b.
- R3: Register 1 (offset 0x4) receives 13'h0AF5 in bits [12:0] in both modes:
  - [1:0] fabric receive clock select = 1
  - [3:2] fabric transmit clock select = 1
  - [5:4] PCS receive clock source = 3
  - [7:6] PCS transmit clock source = 3
  - [9:8] FIFO write clock select = 2
  - [11:10] FIFO read clock select = 2
  - [12] receive FIFO pipe clock = 0
- R4: Register 2 (offset 0x8) bits [7:0] hold the clock enables: [3:0] are the 8b/10b enables, [4] and [5] are the 64b/66b receive/transmit enables, and [6] and [7] are the 64b/66b divide-by-2 receive/transmit enables. The field reads 8'h0F for 8b/10b, 8'hF0 for 64b/66b with a 64-bit fabric, and 8'h30 for 64b/66b with a 32-bit fabric.
- R5: Register 3 (offset 0xC) holds the deserializer width in [2:0] and the serializer width in [6:4]. Both are 3'd7 for 8b/10b and 3'd6 for 64b/66b.
- R6: Register 4 (offset 0x10) holds the slip source select in bit 0 and the slip enable in bit 1. They are 0 and 1 for 8b/10b, and 1 and 0 for 64b/66b.
- R7: Every register is read before it is written. All bits outside its field mask are written back exactly as read.
- R8: One sequence makes exactly ten transfers, alternating read and write at offsets 0x0, 0x4, 0x8, 0xC, 0x10, in that order.
- R9: Each transfer has one setup cycle followed by an access phase. The access phase is held, with stable address and direction, until `pReady` is sampled high.
- R10: `busy` is high from the cycle after acceptance until the sequence ends. `done` is high for exactly one cycle, in the cycle after the last write completes.
- R11: An error response on any transfer ends the sequence at once. `err` pulses for one cycle, no further transfers follow, and `curMode` is unchanged.
- R12: An unsupported rate code (4'h0, 4'h1, 4'hB to 4'hF) is acknowledged. It produces an `err` pulse in the next cycle, no bus transfer, and no change to `curMode`.
- R13: `reqAck` is low while `busy` is high. A request held during a sequence is accepted in the cycle the block becomes idle.
- R14: After reset, `busy`, `done`, `err`, `pSel` and `pEnable` are low and `curMode` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Mode-change request present |
| reqRate | input | 4 | Requested line-rate code |
| reqWide | input | 1 | 1 = 64-bit fabric interface, 0 = 32-bit |
| reqAck | output | 1 | Request taken this cycle |
| pSel | output | 1 | APB select |
| pEnable | output | 1 | APB access phase |
| pWrite | output | 1 | APB direction, 1 = write |
| pAddr | output | ADDR_W | APB byte address |
| pWdata | output | DATA_W | APB write data |
| pRdata | input | DATA_W | APB read data |
| pReady | input | 1 | APB transfer complete |
| pSlvErr | input | 1 | APB error response |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle failure pulse |
| curMode | output | 1 | Active path, 0 = 8b/10b, 1 = 64b/66b |

## Verification
A wrong step index or a stale latched mode shows on the very next write. The wrong field value or address appears at `pWdata` or `pAddr` within four cycles of the previous write. A bad merge register corrupts bits outside the mask, and that damage is visible in the slave's register image as soon as the sequence ends. A state machine stuck or misordered in its phases shows within one transfer: the read/write alternation breaks, a phase drops out of the setup-then-access pattern, or `done`/`err` arrive a cycle early or late relative to the final bus response.

// File: rtl/lms_pkg.sv
package lms_pkg;

  localparam int NUM_STEPS  = 5;
  localparam int STEP_W     = 3;
  localparam int STEP_SLOTS = 1 << STEP_W;
  localparam int FIELD_W    = 16;

  // rate code boundaries
  localparam logic [3:0] RATE_MIN    = 4'h2;
  localparam logic [3:0] RATE_FIRST64 = 4'h8;
  localparam logic [3:0] RATE_MAX    = 4'hA;

  // interface mode encodings (one-hot)
  localparam logic [3:0] IFC_NARROW_CODE = 4'b0100;
  localparam logic [3:0] IFC_WIDE_CODE   = 4'b0010;

  // serdes bus width codes
  localparam logic [2:0] BUS40 = 3'd7;
  localparam logic [2:0] BUS32 = 3'd6;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_SETUP,
    S_RD_ACCESS,
    S_WR_SETUP,
    S_WR_ACCESS
  } lmsStateT;

  typedef struct packed {
    logic latchReq;
    logic mergeRd;
    logic advance;
    logic commitMode;
  } lmsStrobeT;

  function automatic logic rateKnown(input logic [3:0] code);
    return (code >= RATE_MIN) && (code <= RATE_MAX);
  endfunction

  function automatic logic rateIs64(input logic [3:0] code);
    return code >= RATE_FIRST64;
  endfunction

  function automatic logic [FIELD_W-1:0] fieldMask(input int step);
    logic [FIELD_W-1:0] m;
    case (step)
      0:       m = 16'h000F;
      1:       m = 16'h1FFF;
      2:       m = 16'h00FF;
      3:       m = 16'h0077;
      4:       m = 16'h0003;
      default: m = '0;
    endcase
    return m;
  endfunction

  function automatic logic [FIELD_W-1:0] fieldValue(input int step,
                                                    input logic is64,
                                                    input logic wide);
    logic [FIELD_W-1:0] v;
    v = '0;
    case (step)
      0: v[3:0] = is64 ? IFC_WIDE_CODE : IFC_NARROW_CODE;
      1: begin
        v[1:0]   = 2'd1;  // fabric rx clock
        v[3:2]   = 2'd1;  // fabric tx clock
        v[5:4]   = 2'd3;  // pcs rx clock source
        v[7:6]   = 2'd3;  // pcs tx clock source
        v[9:8]   = 2'd2;  // fifo write clock
        v[11:10] = 2'd2;  // fifo read clock
        v[12]    = 1'b0;  // rx fifo pipe clock
      end
      2: begin
        v[3:0] = is64 ? 4'h0 : 4'hF;
        v[4]   = is64;
        v[5]   = is64;
        v[6]   = is64 & wide;
        v[7]   = is64 & wide;
      end
      3: begin
        v[2:0] = is64 ? BUS32 : BUS40;
        v[6:4] = is64 ? BUS32 : BUS40;
      end
      4: begin
        v[0] = is64;   // slip source select
        v[1] = ~is64;  // slip enable
      end
      default: v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/lms_datapath.sv
module lms_datapath
  import lms_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int BASE_ADDR = 0,
  parameter int STRIDE    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  lmsStrobeT         strb,
  input  logic [3:0]        reqRate,
  input  logic              reqWide,
  input  logic [DATA_W-1:0] pRdata,
  output logic              rateOk,
  output logic              lastStep,
  output logic [ADDR_W-1:0] pAddr,
  output logic [DATA_W-1:0] pWdata,
  output logic              curMode
);

  logic [STEP_W-1:0]  stepIdx;
  logic               pendIs64;
  logic               pendWide;
  logic [DATA_W-1:0]  mergeReg;
  logic               modeReg;

  logic [ADDR_W-1:0]  stepAddr [STEP_SLOTS];
  logic [FIELD_W-1:0] stepMask [STEP_SLOTS];
  logic [FIELD_W-1:0] stepVal  [STEP_SLOTS];

  for (genvar g = 0; g < STEP_SLOTS; g++) begin : g_step
    assign stepAddr[g] = ADDR_W'(BASE_ADDR + g * STRIDE);
    assign stepMask[g] = fieldMask(g);
    assign stepVal[g]  = fieldValue(g, pendIs64, pendWide);
  end

  logic [DATA_W-1:0] maskExt;
  logic [DATA_W-1:0] valExt;

  assign maskExt  = DATA_W'(stepMask[stepIdx]);
  assign valExt   = DATA_W'(stepVal[stepIdx]);
  assign rateOk   = rateKnown(reqRate);
  assign lastStep = (stepIdx == STEP_W'(NUM_STEPS - 1));
  assign pAddr    = stepAddr[stepIdx];
  assign pWdata   = mergeReg;
  assign curMode  = modeReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepIdx  <= '0;
      pendIs64 <= 1'b0;
      pendWide <= 1'b0;
      mergeReg <= '0;
      modeReg  <= 1'b0;
    end else begin
      if (strb.latchReq) begin
        pendIs64 <= rateIs64(reqRate);
        pendWide <= reqWide;
        stepIdx  <= '0;
      end else if (strb.advance) begin
        stepIdx <= stepIdx + 1'b1;
      end
      if (strb.mergeRd)
        mergeReg <= (pRdata & ~maskExt) | (valExt & maskExt);
      if (strb.commitMode)
        modeReg <= pendIs64;
    end
  end

  // R8
  step_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    stepIdx < STEP_W'(NUM_STEPS));

endmodule

// File: rtl/lms_ctrl.sv
module lms_ctrl
  import lms_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      rateOk,
  input  logic      lastStep,
  input  logic      pReady,
  input  logic      pSlvErr,
  output logic      reqAck,
  output lmsStrobeT strb,
  output logic      pSel,
  output logic      pEnable,
  output logic      pWrite,
  output logic      busy,
  output logic      done,
  output logic      err
);

  lmsStateT state, stateNext;
  logic     doneSet, errSet;

  always_comb begin
    stateNext = state;
    strb      = '0;
    doneSet   = 1'b0;
    errSet    = 1'b0;
    case (state)
      S_IDLE: begin
        if (reqValid) begin
          if (rateOk) begin
            strb.latchReq = 1'b1;
            stateNext     = S_RD_SETUP;
          end else begin
            errSet = 1'b1;
          end
        end
      end
      S_RD_SETUP: stateNext = S_RD_ACCESS;
      S_RD_ACCESS: begin
        if (pReady) begin
          if (pSlvErr) begin
            errSet    = 1'b1;
            stateNext = S_IDLE;
          end else begin
            strb.mergeRd = 1'b1;
            stateNext    = S_WR_SETUP;
          end
        end
      end
      S_WR_SETUP: stateNext = S_WR_ACCESS;
      S_WR_ACCESS: begin
        if (pReady) begin
          if (pSlvErr) begin
            errSet    = 1'b1;
            stateNext = S_IDLE;
          end else if (lastStep) begin
            doneSet         = 1'b1;
            strb.commitMode = 1'b1;
            stateNext       = S_IDLE;
          end else begin
            strb.advance = 1'b1;
            stateNext    = S_RD_SETUP;
          end
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= doneSet;
      err   <= errSet;
    end
  end

  assign reqAck  = (state == S_IDLE) && reqValid;
  assign busy    = (state != S_IDLE);
  assign pSel    = (state != S_IDLE);
  assign pEnable = (state == S_RD_ACCESS) || (state == S_WR_ACCESS);
  assign pWrite  = (state == S_WR_SETUP) || (state == S_WR_ACCESS);

  // R9
  setup_then_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pSel && !pEnable) |=> (pSel && pEnable && $stable(pWrite)));

  // R9
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pSel && pEnable && !pReady) |=> (pSel && pEnable && $stable(pWrite)));

  // R8
  read_before_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pSel && pEnable && !pWrite && pReady && !pSlvErr) |=> (pSel && !pEnable && pWrite));

  // R13
  no_ack_when_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !reqAck);

  // R10
  done_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && !err));

endmodule

// File: rtl/lane_mode_seq.sv
module lane_mode_seq
  import lms_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int BASE_ADDR = 0,
  parameter int STRIDE    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [3:0]        reqRate,
  input  logic              reqWide,
  output logic              reqAck,
  output logic              pSel,
  output logic              pEnable,
  output logic              pWrite,
  output logic [ADDR_W-1:0] pAddr,
  output logic [DATA_W-1:0] pWdata,
  input  logic [DATA_W-1:0] pRdata,
  input  logic              pReady,
  input  logic              pSlvErr,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              curMode
);

  lmsStrobeT strb;
  logic      rateOk;
  logic      lastStep;

  lms_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .rateOk   (rateOk),
    .lastStep (lastStep),
    .pReady   (pReady),
    .pSlvErr  (pSlvErr),
    .reqAck   (reqAck),
    .strb     (strb),
    .pSel     (pSel),
    .pEnable  (pEnable),
    .pWrite   (pWrite),
    .busy     (busy),
    .done     (done),
    .err      (err)
  );

  lms_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .BASE_ADDR (BASE_ADDR),
    .STRIDE    (STRIDE)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqRate  (reqRate),
    .reqWide  (reqWide),
    .pRdata   (pRdata),
    .rateOk   (rateOk),
    .lastStep (lastStep),
    .pAddr    (pAddr),
    .pWdata   (pWdata),
    .curMode  (curMode)
  );

  // R12
  bad_rate_no_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqAck && ((reqRate < 4'h2) || (reqRate > 4'hA))) |=> (err && !pSel && !busy));

  // R11
  err_keeps_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    err |-> $stable(curMode));

  // R2
  ifc_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pSel && pEnable && pWrite && (pAddr == ADDR_W'(BASE_ADDR))) |-> $onehot(pWdata[3:0]));

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pSel && pEnable && !pReady) |=> $stable(pAddr));

endmodule

// File: tb/lane_mode_seq_bench.sv
module lane_mode_seq_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [3:0]  reqRate = 4'h0;
  logic        reqWide = 1'b0;
  logic        reqAck;
  logic        pSel, pEnable, pWrite;
  logic [11:0] pAddr;
  logic [31:0] pWdata;
  logic [31:0] pRdata = '0;
  logic        pReady = 1'b0;
  logic        pSlvErr = 1'b0;
  logic        busy, done, err, curMode;

  always #10 clk = ~clk;  // 50 MHz

  lane_mode_seq u_lane_mode_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRate(reqRate), .reqWide(reqWide),
    .reqAck(reqAck), .pSel(pSel), .pEnable(pEnable), .pWrite(pWrite), .pAddr(pAddr),
    .pWdata(pWdata), .pRdata(pRdata), .pReady(pReady), .pSlvErr(pSlvErr),
    .busy(busy), .done(done), .err(err), .curMode(curMode)
  );

  int vectors = 0;
  int fails = 0;

  // slave model
  logic [31:0] mem [5];
  logic [12:0] xlog [16];
  int xferCount = 0;
  int slvWaits = 0;
  int waitCnt = 0;
  int errAt = -1;

  always @(negedge clk) begin
    if (rstN && pSel && pEnable) begin
      if (waitCnt < slvWaits) begin
        waitCnt++;
        pReady = 1'b0;
      end else begin
        pReady = 1'b1;
        if (xferCount < 16) xlog[xferCount] = {pWrite, pAddr};
        if (xferCount == errAt) begin
          pSlvErr = 1'b1;
        end else begin
          pSlvErr = 1'b0;
          if (pAddr[11:2] < 5) begin
            if (pWrite) mem[pAddr[11:2]] = pWdata;
            else pRdata = mem[pAddr[11:2]];
          end
        end
        xferCount++;
      end
    end else begin
      pReady = 1'b0;
      pSlvErr = 1'b0;
      waitCnt = 0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  function automatic logic [31:0] initVal(input int i);
    return 32'hDEAD_BEEF + i * 32'h0131_0507;
  endfunction

  function automatic logic [31:0] expMask(input int i);
    case (i)
      0: return 32'h0000_000F;
      1: return 32'h0000_1FFF;
      2: return 32'h0000_00FF;
      3: return 32'h0000_0077;
      default: return 32'h0000_0003;
    endcase
  endfunction

  function automatic logic [31:0] expField(input int i, input logic m64, input logic w);
    case (i)
      0: return m64 ? 32'h2 : 32'h4;
      1: return 32'h0AF5;
      2: return m64 ? (w ? 32'hF0 : 32'h30) : 32'h0F;
      3: return m64 ? 32'h66 : 32'h77;
      default: return m64 ? 32'h1 : 32'h2;
    endcase
  endfunction

  task automatic prepSlave(input int waits, input int errIdx);
    for (int i = 0; i < 5; i++) mem[i] = initVal(i);
    xferCount = 0;
    slvWaits = waits;
    errAt = errIdx;
  endtask

  // drives a request and returns at the first negedge after acceptance
  task automatic issue(input logic [3:0] rate, input logic wide);
    int guard = 0;
    @(negedge clk);
    reqValid = 1'b1;
    reqRate = rate;
    reqWide = wide;
    #1;
    while (!reqAck && guard < 5000) begin
      tick();
      guard++;
    end
    @(negedge clk);
    reqValid = 1'b0;
    #1;
  endtask

  task automatic waitEnd(output int cyc);
    cyc = 0;
    while (!done && !err && cyc < 5000) begin
      tick();
      cyc++;
    end
  endtask

  task automatic testReset();
    chk("R14 busy", 32'(busy), 0);
    chk("R14 done", 32'(done), 0);
    chk("R14 err", 32'(err), 0);
    chk("R14 pSel", 32'(pSel), 0);
    chk("R14 pEnable", 32'(pEnable), 0);
    chk("R14 curMode", 32'(curMode), 0);
    chk("R14 reqAck", 32'(reqAck), 0);
  endtask

  task automatic testSwitch(input logic [3:0] rate, input logic wide, input int waits);
    int cyc;
    logic m64;
    m64 = (rate >= 4'h8);
    prepSlave(waits, -1);
    issue(rate, wide);
    chk("R10 busy after accept", 32'(busy), 1);
    waitEnd(cyc);
    chk("R10 done pulse", 32'(done), 1);
    chk("R10 busy cleared", 32'(busy), 0);
    chk("R1 curMode", 32'(curMode), 32'(m64));
    chk("R8 transfer count", 32'(xferCount), 10);
    for (int k = 0; k < 5; k++) begin
      chk("R8 read order", 32'(xlog[2*k]), 32'({1'b0, 12'(k*4)}));
      chk("R8 write order", 32'(xlog[2*k+1]), 32'({1'b1, 12'(k*4)}));
    end
    chk("R2 ifc field", mem[0] & expMask(0), expField(0, m64, wide));
    chk("R3 clksel field", mem[1] & expMask(1), expField(1, m64, wide));
    chk("R4 clken field", mem[2] & expMask(2), expField(2, m64, wide));
    chk("R5 width field", mem[3] & expMask(3), expField(3, m64, wide));
    chk("R6 slip field", mem[4] & expMask(4), expField(4, m64, wide));
    for (int i = 0; i < 5; i++)
      chk("R7 untouched bits", mem[i] & ~expMask(i), initVal(i) & ~expMask(i));
    tick();
    chk("R10 done one cycle", 32'(done), 0);
  endtask

  task automatic testBadRate(input logic [3:0] rate);
    logic prevMode;
    prevMode = curMode;
    prepSlave(0, -1);
    issue(rate, 1'b1);
    chk("R12 err pulse", 32'(err), 1);
    chk("R12 not busy", 32'(busy), 0);
    tick();
    tick();
    chk("R12 no transfers", 32'(xferCount), 0);
    chk("R12 mode kept", 32'(curMode), 32'(prevMode));
    chk("R12 err one cycle", 32'(err), 0);
  endtask

  task automatic testSlvErr(input logic [3:0] rate, input int at);
    int cyc;
    logic prevMode;
    prevMode = curMode;
    prepSlave(1, at);
    issue(rate, 1'b0);
    waitEnd(cyc);
    chk("R11 err pulse", 32'(err), 1);
    chk("R11 no done", 32'(done), 0);
    chk("R11 mode kept", 32'(curMode), 32'(prevMode));
    for (int i = 0; i < 4; i++) tick();
    chk("R11 transfers stop", 32'(xferCount), 32'(at + 1));
    chk("R11 bus idle", 32'(pSel), 0);
  endtask

  task automatic testHoldOff();
    int cyc;
    int ackWhileBusy;
    ackWhileBusy = 0;
    cyc = 0;
    prepSlave(2, -1);
    issue(4'h9, 1'b1);
    @(negedge clk);
    reqValid = 1'b1;
    reqRate = 4'h3;
    reqWide = 1'b0;
    #1;
    while (busy && cyc < 5000) begin
      if (reqAck) ackWhileBusy++;
      tick();
      cyc++;
    end
    chk("R13 ack held low", 32'(ackWhileBusy), 0);
    chk("R13 first done", 32'(done), 1);
    chk("R13 accepted when idle", 32'(reqAck), 1);
    chk("R1 first mode", 32'(curMode), 1);
    @(negedge clk);
    reqValid = 1'b0;
    #1;
    chk("R13 second busy", 32'(busy), 1);
    waitEnd(cyc);
    chk("R13 second done", 32'(done), 1);
    chk("R1 second mode", 32'(curMode), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    prepSlave(0, -1);
    repeat (3) @(negedge clk);
    #1;
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    #1;
    testReset();
    testSwitch(4'h8, 1'b1, 0);   // R4 wide
    testSwitch(4'h5, 1'b0, 1);   // back to 8b/10b
    testSwitch(4'hA, 1'b0, 3);   // R4 narrow, 7a rate
    testSwitch(4'h2, 1'b1, 0);
    testSwitch(4'h7, 1'b0, 2);
    testSwitch(4'h9, 1'b1, 1);
    testBadRate(4'h1);
    testBadRate(4'hB);
    testBadRate(4'h0);
    testSlvErr(4'h3, 4);         // error on a read
    testSlvErr(4'h6, 7);         // error on a write
    testSlvErr(4'h4, 0);         // error on first access
    testHoldOff();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule